// File: doc/BRIEF.md
# Header Field Slice Extractor

This block builds a classification key from an Ethernet frame as it streams past one byte per beat. Software programs a table of nine slice descriptors. Each descriptor picks one 16-bit field of the header. It places that field relative to one of two reference points: the end of the link-layer header, or the end of the IPv4 header. The distance from the reference point is counted in two-byte units.

The extracted fields are packed into a wide key, and each slice has one valid bit. A one-cycle strobe marks the point where the key is final for the frame. A classifier downstream compares the key against its rules.

The descriptor table sits behind a small write port. A write is staged and does not take effect until the next frame starts. A frame that is already in flight therefore always sees one consistent table.

Top module: `hdr_slice_extractor`

## Requirements
- R1: After reset, `key_o`, `slice_valid_o` and `key_valid_o` are all zero, and every descriptor reads as unused.
- R2: Descriptor bit 7 selects the reference point: 1 is the end of the IPv4 header and 0 is the end of the link-layer header. Bits [5:0] give an offset in 16-bit units. The field's first byte sits at byte number reference + 2*offset, and its second byte follows it. Bit 6 has no effect on where the field is placed.
- R3: A descriptor equal to zero disables its slice, so that slice's valid bit stays low. Any nonzero value enables the slice.
- R4: Bytes are numbered from 0 at the start-of-frame beat. The link-layer header ends at byte 14. The IPv4 header ends at byte 14 + 4*IHL, where IHL is the low nibble of byte 14.
- R5: Slice i occupies `key_o[16*i+15:16*i]`. The first target byte lands in the upper eight bits of that range and the second target byte in the lower eight.
- R6: A slice's valid bit rises only once both of its bytes have arrived within the frame. If a target byte would fall after the end-of-frame beat, the valid bit stays low.
- R7: `key_valid_o` is high for exactly one cycle per frame. It rises in the cycle after the beat that completes the last enabled slice. If the frame ends first, it rises in the cycle after the end-of-frame beat instead.
- R8: `key_o` and `slice_valid_o` hold their values in every cycle without a beat. A valid bit never falls within a frame. Both outputs clear on the next start-of-frame beat.
- R9: A write to address a < 9 stores the descriptor for slice a, and writes to higher addresses are ignored. A stored value is picked up by the first start-of-frame beat in a later cycle than the write. A frame in flight keeps the table it latched at its start.
- R10: Load the layout 0x06, 0x07, 0x08, 0x09, 0x80, 0x81 into slices 0 to 5, and send a 60-byte IPv4 frame with IHL 5. The result is `slice_valid_o` = 0x03F, and slice 0 holds frame bytes 26 and 27 (the upper half of the source address).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A frame byte is present this cycle |
| in_sop_i | input | 1 | This byte is the first byte of the frame |
| in_eop_i | input | 1 | This byte is the last byte of the frame |
| in_data_i | input | 8 | Frame byte |
| cfg_we_i | input | 1 | Write strobe for the descriptor table |
| cfg_addr_i | input | 8 | Descriptor index |
| cfg_wdata_i | input | 8 | Descriptor value |
| key_o | output | 144 | Packed extracted fields, slice i at bits [16*i+15:16*i] |
| slice_valid_o | output | 9 | Per-slice valid bits |
| key_valid_o | output | 1 | One-cycle strobe: the key is final for this frame |

## Verification
On every cycle, the assertions check four things. Valid bits only appear for slices whose latched descriptor is nonzero. The key and valid vector are frozen in idle cycles, and valid bits never drop mid-frame. The latched table only changes on a start-of-frame beat. The strobe only fires with every enabled slice complete, or straight after an end-of-frame beat.

The rest can only be shown by the bench's scenarios, because it depends on the frame contents:
- the byte placement worked out from IHL, including IHL 0 and IHL 6;
- truncation by a short frame;
- ignored out-of-range writes;
- a descriptor written mid-frame that stays deferred until the next frame;
- the exact cycle of the strobe.

// File: rtl/hse_pkg.sv
package hse_pkg;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 16;
  localparam int DESC_W  = 8;
  localparam int OFF_W   = 6;

  typedef struct packed {
    logic             l3_sel;
    logic             rsvd;
    logic [OFF_W-1:0] off;
  } desc_t;
endpackage

// File: rtl/hse_cfg_table.sv
module hse_cfg_table
  import hse_pkg::*;
#(
  parameter int N  = 9,
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DESC_W-1:0] wdata_i,
  input  logic              sop_beat_i,
  output desc_t [N-1:0]     act_o,
  output desc_t [N-1:0]     eff_o
);
  desc_t [N-1:0] shadow_q;
  desc_t [N-1:0] act_q;

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[g] <= '0;
        act_q[g]    <= '0;
      end else begin
        if (we_i && addr_i == AW'(g)) shadow_q[g] <= desc_t'(wdata_i);
        if (sop_beat_i)               act_q[g]    <= shadow_q[g];
      end
    end
    // a new frame sees the staged table on its first beat
    assign eff_o[g] = sop_beat_i ? shadow_q[g] : act_q[g];
  end

  assign act_o = act_q;
endmodule

// File: rtl/hse_hdr_tracker.sv
module hse_hdr_tracker #(
  parameter int CNT_W  = 11,
  parameter int L2_LEN = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_sop_i,
  input  logic             in_eop_i,
  input  logic [3:0]       ihl_nib_i,
  output logic             beat_o,
  output logic             sop_beat_o,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] l3_base_o,
  output logic             l3_known_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             in_frame_q;
  logic [3:0]       ihl_q;
  logic             ihl_known_q;
  logic             at_ihl;
  logic [3:0]       ihl_now;

  assign beat_o     = in_valid_i && (in_sop_i || in_frame_q);
  assign sop_beat_o = in_valid_i && in_sop_i;
  assign pos_o      = in_sop_i ? '0 : cnt_q;
  assign at_ihl     = beat_o && pos_o == CNT_W'(L2_LEN);
  assign ihl_now    = at_ihl ? ihl_nib_i : ihl_q;
  assign l3_known_o = at_ihl || (ihl_known_q && !sop_beat_o);
  assign l3_base_o  = CNT_W'(L2_LEN) + CNT_W'({ihl_now, 2'b00});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      in_frame_q  <= 1'b0;
      ihl_q       <= '0;
      ihl_known_q <= 1'b0;
    end else if (beat_o) begin
      cnt_q      <= (pos_o == '1) ? pos_o : pos_o + 1'b1;
      in_frame_q <= !in_eop_i;
      if (sop_beat_o) ihl_known_q <= 1'b0;
      if (at_ihl) begin
        ihl_q       <= ihl_nib_i;
        ihl_known_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hse_slice_unit.sv
module hse_slice_unit
  import hse_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int L2_LEN = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               beat_i,
  input  logic               sop_beat_i,
  input  logic [CNT_W-1:0]   pos_i,
  input  logic [BYTE_W-1:0]  data_i,
  input  logic [CNT_W-1:0]   l3_base_i,
  input  logic               l3_known_i,
  input  desc_t              desc_i,
  output logic [FIELD_W-1:0] field_o,
  output logic               got_o,
  output logic               got_nxt_o,
  output logic               used_o
);
  logic [CNT_W-1:0] base, t_hi, t_lo;
  logic             known, cap_en, hit_hi, hit_lo;
  logic             got_q;
  logic [FIELD_W-1:0] field_q;

  assign used_o = |desc_i;
  assign known  = desc_i.l3_sel ? l3_known_i : 1'b1;
  assign base   = desc_i.l3_sel ? l3_base_i : CNT_W'(L2_LEN);
  assign t_hi   = base + CNT_W'({desc_i.off, 1'b0});
  assign t_lo   = t_hi + 1'b1;
  assign cap_en = beat_i && !sop_beat_i && used_o && known;
  assign hit_hi = cap_en && pos_i == t_hi;
  assign hit_lo = cap_en && pos_i == t_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= '0;
      got_q   <= 1'b0;
    end else if (sop_beat_i) begin
      field_q <= '0;
      got_q   <= 1'b0;
    end else begin
      if (hit_hi) field_q[FIELD_W-1:BYTE_W] <= data_i;
      if (hit_lo) begin
        field_q[BYTE_W-1:0] <= data_i;
        got_q               <= 1'b1;
      end
    end
  end

  assign field_o   = field_q;
  assign got_o     = got_q;
  assign got_nxt_o = sop_beat_i ? 1'b0 : (got_q | hit_lo);
endmodule

// File: rtl/hdr_slice_extractor.sv
module hdr_slice_extractor
  import hse_pkg::*;
#(
  parameter int NUM_SLICES = 9,
  parameter int CFG_AW     = 8,
  parameter int CNT_W      = 11,
  parameter int L2_LEN     = 14
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  input  logic                          in_sop_i,
  input  logic                          in_eop_i,
  input  logic [BYTE_W-1:0]             in_data_i,
  input  logic                          cfg_we_i,
  input  logic [CFG_AW-1:0]             cfg_addr_i,
  input  logic [DESC_W-1:0]             cfg_wdata_i,
  output logic [NUM_SLICES*FIELD_W-1:0] key_o,
  output logic [NUM_SLICES-1:0]         slice_valid_o,
  output logic                          key_valid_o
);
  desc_t [NUM_SLICES-1:0] act_tbl;
  desc_t [NUM_SLICES-1:0] eff_tbl;
  logic                   beat, sop_beat, l3_known;
  logic [CNT_W-1:0]       pos, l3_base;
  logic [NUM_SLICES-1:0]  got_v, got_nxt_v, used_v;
  logic                   done_q, done_eff, fire, kv_q;

  hse_cfg_table #(.N(NUM_SLICES), .AW(CFG_AW)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .sop_beat_i (sop_beat),
    .act_o      (act_tbl),
    .eff_o      (eff_tbl)
  );

  hse_hdr_tracker #(.CNT_W(CNT_W), .L2_LEN(L2_LEN)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_sop_i   (in_sop_i),
    .in_eop_i   (in_eop_i),
    .ihl_nib_i  (in_data_i[3:0]),
    .beat_o     (beat),
    .sop_beat_o (sop_beat),
    .pos_o      (pos),
    .l3_base_o  (l3_base),
    .l3_known_o (l3_known)
  );

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    hse_slice_unit #(.CNT_W(CNT_W), .L2_LEN(L2_LEN)) u_sl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .beat_i     (beat),
      .sop_beat_i (sop_beat),
      .pos_i      (pos),
      .data_i     (in_data_i),
      .l3_base_i  (l3_base),
      .l3_known_i (l3_known),
      .desc_i     (eff_tbl[g]),
      .field_o    (key_o[g*FIELD_W +: FIELD_W]),
      .got_o      (got_v[g]),
      .got_nxt_o  (got_nxt_v[g]),
      .used_o     (used_v[g])
    );
  end

  assign done_eff = sop_beat ? 1'b0 : done_q;
  assign fire     = beat && !done_eff && (((used_v & ~got_nxt_v) == '0) || in_eop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      kv_q   <= 1'b0;
    end else begin
      kv_q <= fire;
      if (beat) done_q <= done_eff | fire;
    end
  end

  assign slice_valid_o = got_v;
  assign key_valid_o   = kv_q;
endmodule

// File: rtl/hse_checker.sv
module hse_checker #(
  parameter int N = 9
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           in_valid_i,
  input logic           in_sop_i,
  input logic           in_eop_i,
  input logic [N*16-1:0] key_o,
  input logic [N-1:0]   slice_valid_o,
  input logic           key_valid_o,
  input logic [N*8-1:0] act_i
);
  logic [N-1:0] used_m;
  always_comb begin
    for (int i = 0; i < N; i++) used_m[i] = |act_i[8*i +: 8];
  end

  AST_VALID_NEEDS_DESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slice_valid_o & ~used_m) == '0); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(slice_valid_o) && $stable(key_o))); // R8

  AST_VALID_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_sop_i) |=> ((slice_valid_o & $past(slice_valid_o)) == $past(slice_valid_o))); // R8

  AST_KV_COMPLETE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> ((slice_valid_o == used_m) || $past(in_valid_i && in_eop_i))); // R7

  AST_TABLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_sop_i) |=> $stable(act_i)); // R9
endmodule

bind hdr_slice_extractor hse_checker #(.N(NUM_SLICES)) u_hse_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_sop_i      (in_sop_i),
  .in_eop_i      (in_eop_i),
  .key_o         (key_o),
  .slice_valid_o (slice_valid_o),
  .key_valid_o   (key_valid_o),
  .act_i         (act_tbl)
);

// File: tb/tb_hdr_slice_extractor.sv
module tb_hdr_slice_extractor;
  localparam int N  = 9;
  localparam int KW = N * 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0, in_sop_i = 1'b0, in_eop_i = 1'b0;
  logic [7:0]    in_data_i = '0;
  logic          cfg_we_i = 1'b0;
  logic [7:0]    cfg_addr_i = '0, cfg_wdata_i = '0;
  logic [KW-1:0] key_o;
  logic [N-1:0]  slice_valid_o;
  logic          key_valid_o;

  always #10 clk = ~clk;

  hdr_slice_extractor dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_sop_i(in_sop_i), .in_eop_i(in_eop_i), .in_data_i(in_data_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .key_o(key_o), .slice_valid_o(slice_valid_o), .key_valid_o(key_valid_o)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  int shadow[N], act[N];
  int fb[$];
  bit m_done = 0, m_kv = 0;
  logic [N-1:0]  m_valid = '0;
  logic [KW-1:0] m_key = '0;
  int unsigned   seed = 32'h1234_5678;

  function automatic void check(bit ok, string tag, string what, logic [KW-1:0] a, logic [KW-1:0] e);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, a, e);
    end
  endfunction

  function automatic void model_eval();
    for (int i = 0; i < N; i++) begin
      int d = act[i];
      int base = -1;
      int t;
      logic [7:0] hi = 8'h00, lo = 8'h00;
      m_valid[i] = 1'b0;
      if (d != 0) begin
        if ((d & 128) != 0) begin
          if (fb.size() > 14) base = 14 + 4 * (fb[14] & 15);
        end else base = 14;
        if (base >= 0) begin
          t = base + 2 * (d & 63);
          if (fb.size() > t) hi = 8'(fb[t]);
          if (fb.size() > t + 1) begin
            lo = 8'(fb[t+1]);
            m_valid[i] = 1'b1;
          end
        end
      end
      m_key[16*i +: 16] = {hi, lo};
    end
  endfunction

  function automatic logic [N-1:0] used_mask();
    logic [N-1:0] u;
    for (int i = 0; i < N; i++) u[i] = (act[i] != 0);
    return u;
  endfunction

  task automatic step(bit v, bit s, bit e, int d, bit we, int wa, int wd, string tag);
    in_valid_i = v; in_sop_i = s; in_eop_i = e; in_data_i = 8'(d);
    cfg_we_i = we; cfg_addr_i = 8'(wa); cfg_wdata_i = 8'(wd);
    @(posedge clk);
    if (v && s) begin
      for (int i = 0; i < N; i++) act[i] = shadow[i];
      fb.delete();
      m_done = 0;
    end
    if (we && wa < N) shadow[wa] = wd;
    m_kv = 0;
    if (v) begin
      fb.push_back(d & 255);
      model_eval();
      if (!m_done && (((used_mask() & ~m_valid) == '0) || e)) begin
        m_kv = 1; m_done = 1;
      end
    end
    @(negedge clk);
    in_valid_i = 0; in_sop_i = 0; in_eop_i = 0; cfg_we_i = 0;
    check(slice_valid_o == m_valid, tag, "slice_valid", KW'(slice_valid_o), KW'(m_valid));
    check(key_o == m_key, tag, "key", key_o, m_key);
    check(key_valid_o == m_kv, tag, "key_valid R7", KW'(key_valid_o), KW'(m_kv));
  endtask

  task automatic send_frame(int len, int ihl, bit gap, string tag, int wr_at, int wa, int wd);
    for (int p = 0; p < len; p++) begin
      int d;
      seed = seed * 1103515245 + 12345;
      d = (p == 14) ? (8'h40 | ihl) : int'(seed[23:16]);
      if (gap && (p % 3 == 1)) step(0, 0, 0, 0, 0, 0, 0, tag);
      step(1, p == 0, p == len - 1, d, p == wr_at, wa, wd, tag);
    end
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic cfg(int wa, int wd, string tag);
    step(0, 0, 0, 0, 1, wa, wd, tag);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_tests++; n_fail++;
      $display("FAIL R7 watchdog: actual %0d cycles expected < 50000", cyc);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin shadow[i] = 0; act[i] = 0; end
    repeat (3) @(negedge clk);
    check(key_o == '0, "R1", "reset key", key_o, '0);
    check(slice_valid_o == '0, "R1", "reset valid", KW'(slice_valid_o), '0);
    check(key_valid_o == 1'b0, "R1", "reset key_valid", KW'(key_valid_o), '0);
    rst_ni = 1'b1;
    @(negedge clk);

    send_frame(20, 5, 0, "R1", -1, 0, 0);

    cfg(0, 8'h06, "R2"); cfg(1, 8'h07, "R2"); cfg(2, 8'h08, "R2");
    cfg(3, 8'h09, "R2"); cfg(4, 8'h80, "R2"); cfg(5, 8'h81, "R2");

    send_frame(60, 5, 0, "R5", -1, 0, 0);
    check(slice_valid_o == 9'h03f, "R10", "std layout valid", KW'(slice_valid_o), KW'(9'h03f));
    check(key_o[15:0] == {8'(fb[26]), 8'(fb[27])}, "R10", "src ip hi", KW'(key_o[15:0]),
          KW'({8'(fb[26]), 8'(fb[27])}));

    send_frame(60, 6, 0, "R4", -1, 0, 0);
    check(slice_valid_o == 9'h03f, "R4", "ihl6 valid", KW'(slice_valid_o), KW'(9'h03f));
    send_frame(36, 5, 0, "R6", -1, 0, 0);
    check(slice_valid_o == 9'h01f, "R6", "short frame valid", KW'(slice_valid_o), KW'(9'h01f));
    send_frame(60, 0, 0, "R4", -1, 0, 0);
    send_frame(50, 5, 1, "R8", -1, 0, 0);

    cfg(12, 8'h05, "R9");
    cfg(1, 8'h00, "R3");
    cfg(7, 8'h46, "R2");
    send_frame(60, 5, 0, "R3", -1, 0, 0);
    check(slice_valid_o == 9'h0bd, "R3", "zero desc valid", KW'(slice_valid_o), KW'(9'h0bd));
    check(key_o[7*16 +: 16] == {8'(fb[26]), 8'(fb[27])}, "R2", "bit6 ignored",
          KW'(key_o[7*16 +: 16]), KW'({8'(fb[26]), 8'(fb[27])}));

    send_frame(60, 5, 0, "R9", 10, 8, 8'h0a);
    check(slice_valid_o == 9'h0bd, "R9", "mid-frame write deferred", KW'(slice_valid_o), KW'(9'h0bd));
    send_frame(60, 5, 0, "R9", -1, 0, 0);
    check(slice_valid_o == 9'h1bd, "R9", "write applied next frame", KW'(slice_valid_o), KW'(9'h1bd));

    send_frame(1, 5, 0, "R7", -1, 0, 0);
    send_frame(16, 5, 1, "R7", -1, 0, 0);

    finish_run();
  end
endmodule